// File: doc/BRIEF.md
# Spectral Kurtosis Accumulator Engine

This block sits behind a streaming FFT and estimates, for every positive-frequency bin, a fourth-order statistic that separates steady tones, tones whose amplitude changes from frame to frame, and noise. It takes one complex bin per clock. For each bin in the lower half of every frame it forms the power P = re² + im² and P². Two running sums are kept per bin, and the block never stalls the FFT while it accumulates.

Once the configured number of frames has been summed, the block makes a single pipelined finishing pass over the bins. For each bin it evaluates frames·ΣP² / (ΣP)² in exact fixed point and converts the value to IEEE-754 single precision. It writes each result into a result memory, one entry per bin. A slower serial sender can read that memory later through a synchronous read port. A one-cycle done pulse marks the point where the whole result set is available. The next start-of-frame then begins a new set, with the sums restarted from zero.

Top module: `spec_kurt_engine`

## Requirements
- R1: After reset is released, `done` is low and no result set is in progress.
- R2: A frame begins with a valid bin that has `bin_sof` high. Only the first N/2 valid bins of a frame are accumulated, as bins 0 to N/2-1. Valid bins after them, whether from the upper half or strays without a new start-of-frame, have no effect on any result.
- R3: A cycle with `bin_vld` low neither accumulates its data nor advances the bin index, whatever values sit on the data inputs.
- R4: A bin that has the same nonzero value in every frame of a set yields exactly 0x3F800000 (1.0).
- R5: Each result equals FRAMES·Σ(P²) / (ΣP)² with P = re² + im². It is written as a positive normal single-precision value (sign bit 31 = 0, biased exponent in bits 30:23, fraction in bits 22:0), and the fraction is truncated toward zero.
- R6: A bin whose power is zero in every frame yields 0x00000000.
- R7: The result for bin k is stored at address k. `rd_data` shows the entry that `rd_addr` selected one clock earlier. After the last entry is written, `done` is high for exactly one cycle.
- R8: `done` rises no more than N/2 + 60 cycles after the last counted bin of the final frame is presented.
- R9: Bins presented while a finishing pass is running are ignored. The next result set depends only on its own frames, because sums from the previous set are discarded.
- R10: Full-scale inputs, including -32768 on both parts in every frame, do not overflow the sums. Such a constant bin still yields exactly 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bin_vld | input | 1 | Bin strobe: the data inputs carry a bin this cycle |
| bin_sof | input | 1 | Marks the first bin of a frame (with bin_vld) |
| bin_re | input | IN_W | Signed real part of the bin |
| bin_im | input | IN_W | Signed imaginary part of the bin |
| rd_addr | input | AW | Result memory read address (bin index) |
| rd_data | output | 32 | Single-precision result, one cycle after rd_addr |
| done | output | 1 | One-cycle pulse when all N/2 results are written |

## Verification
Each of two result sets drives eight bins with different patterns:
- A steady tone, which must give exactly 1.0.
- An all-zero bin, which exercises the divide-by-zero guard.
- Ramps and sparse bursts, which give ratios away from 1. A single burst in one frame gives exactly FRAMES.
- Full-scale constant and alternating values, which probe the width of the sums.

Upper-half bins, stray bins after each frame and invalid cycles inside a frame all carry large values, so any leak shows up as a wrong ratio in the lower bins. A start-of-frame stream is injected during the first finishing pass, and the second set uses different values, which shows whether the sums restart cleanly. The expected words come from an independent exact-integer search for exponent and fraction.

// File: rtl/sk_pkg.sv
package sk_pkg;
  typedef enum logic {SK_ACC, SK_FIN} sk_state_e;
  localparam int SK_QBITS = 25;
  localparam logic [7:0] SK_BIAS = 8'd127;
endpackage

// File: rtl/ske_front.sv
module ske_front #(
  parameter int IN_W   = 16,
  parameter int HALF   = 1024,
  parameter int FRAMES = 1000,
  parameter int AW     = 10,
  parameter int CNT_W  = 10,
  parameter int P2_W   = 33,
  parameter int P4_W   = 66
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic                   set_clr,
  input  logic                   bin_vld,
  input  logic                   bin_sof,
  input  logic signed [IN_W-1:0] bin_re,
  input  logic signed [IN_W-1:0] bin_im,
  output logic                   o_vld,
  output logic [AW-1:0]          o_idx,
  output logic                   o_first,
  output logic                   o_last,
  output logic [P2_W-1:0]        o_p2,
  output logic [P4_W-1:0]        o_p4
);
  logic [AW-1:0]    idx_q, idx_d, cur_idx;
  logic             run_q, run_d;
  logic [CNT_W-1:0] frm_q, frm_d;
  logic             take, end_bin, frm_open;

  always_comb begin
    cur_idx  = bin_sof ? '0 : idx_q;
    frm_open = (frm_q != CNT_W'(FRAMES));
    take     = bin_vld && acc_en && frm_open && (bin_sof || run_q);
    end_bin  = (cur_idx == AW'(HALF - 1));
    idx_d    = idx_q;
    run_d    = run_q;
    frm_d    = frm_q;
    if (take) begin
      idx_d = cur_idx + AW'(1);
      run_d = !end_bin;
      if (end_bin) frm_d = frm_q + CNT_W'(1);
    end
    if (set_clr) frm_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      run_q <= 1'b0;
      frm_q <= '0;
    end else begin
      idx_q <= idx_d;
      run_q <= run_d;
      frm_q <= frm_d;
    end
  end

  // three-stage power pipeline
  logic                   v0, v1, v2;
  logic [AW-1:0]          i0, i1, i2;
  logic                   f0, f1, f2, l0, l1, l2;
  logic signed [IN_W-1:0] re0, im0;
  logic signed [2*IN_W-1:0] sq_re, sq_im;
  logic [P2_W-1:0]        p2_1, p2_2;
  logic [P4_W-1:0]        p4_2;

  always_comb begin
    sq_re = re0 * re0;
    sq_im = im0 * im0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v0 <= take;
      v1 <= v0;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      i0  <= cur_idx;
      f0  <= (frm_q == '0);
      l0  <= end_bin && (frm_q == CNT_W'(FRAMES - 1));
      re0 <= bin_re;
      im0 <= bin_im;
    end
    if (v0) begin
      i1   <= i0;
      f1   <= f0;
      l1   <= l0;
      p2_1 <= P2_W'(unsigned'(sq_re)) + P2_W'(unsigned'(sq_im));
    end
    if (v1) begin
      i2   <= i1;
      f2   <= f1;
      l2   <= l1;
      p2_2 <= p2_1;
      p4_2 <= P4_W'(p2_1) * P4_W'(p2_1);
    end
  end

  assign o_vld   = v2;
  assign o_idx   = i2;
  assign o_first = f2;
  assign o_last  = l2;
  assign o_p2    = p2_2;
  assign o_p4    = p4_2;
endmodule

// File: rtl/ske_ratio.sv
module ske_ratio #(
  parameter int AW    = 10,
  parameter int FRAMES = 1000,
  parameter int CNT_W = 10,
  parameter int S2_W  = 43,
  parameter int S4_W  = 76
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_vld,
  input  logic [AW-1:0]   i_addr,
  input  logic [S2_W-1:0] i_s2,
  input  logic [S4_W-1:0] i_s4,
  output logic            o_vld,
  output logic [AW-1:0]   o_addr,
  output logic [31:0]     o_f32
);
  import sk_pkg::*;
  localparam int NW  = S4_W + CNT_W;
  localparam int LZW = $clog2(NW + 1);
  localparam int QB  = SK_QBITS;

  function automatic logic [LZW-1:0] lead0(input logic [NW-1:0] v);
    logic [LZW-1:0] n;
    logic           hit;
    n   = LZW'(NW);
    hit = 1'b0;
    for (int b = NW - 1; b >= 0; b--) begin
      if (!hit && v[b]) begin
        n   = LZW'(NW - 1 - b);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  // stage A: numerator and denominator
  logic          va;
  logic [AW-1:0] ad_a;
  logic [NW-1:0] num_a, den_a;
  logic          zr_a;
  logic [LZW-1:0] lzn, lzd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va <= 1'b0;
    else        va <= i_vld;
  end

  always_ff @(posedge clk) begin
    if (i_vld) begin
      ad_a  <= i_addr;
      num_a <= NW'(i_s4) * NW'(FRAMES);
      den_a <= NW'(i_s2) * NW'(i_s2);
      zr_a  <= (i_s2 == '0);
    end
  end

  always_comb begin
    lzn = lead0(num_a);
    lzd = lead0(den_a);
  end

  // normalise (index 0) then QB restoring-division stages
  logic          vl  [0:QB];
  logic [AW-1:0] ad  [0:QB];
  logic [QB-1:0] qt  [0:QB];
  logic [7:0]    ex  [0:QB];
  logic          zr  [0:QB];
  logic [NW:0]   rem [0:QB-1];
  logic [NW-1:0] dvs [0:QB-1];
  logic          ge   [0:QB-1];
  logic [NW-1:0] rnext [0:QB-1];

  always_comb begin
    for (int k = 0; k < QB; k++) begin
      ge[k]    = (rem[k] >= {1'b0, dvs[k]});
      rnext[k] = ge[k] ? NW'(rem[k] - {1'b0, dvs[k]}) : rem[k][NW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= QB; k++) vl[k] <= 1'b0;
    end else begin
      vl[0] <= va;
      for (int k = 0; k < QB; k++) vl[k+1] <= vl[k];
    end
  end

  always_ff @(posedge clk) begin
    if (va) begin
      ad[0]  <= ad_a;
      zr[0]  <= zr_a;
      qt[0]  <= '0;
      ex[0]  <= SK_BIAS + 8'(lzd) - 8'(lzn);
      rem[0] <= {1'b0, num_a << lzn};
      dvs[0] <= den_a << lzd;
    end
    for (int k = 0; k < QB; k++) begin
      if (vl[k]) begin
        ad[k+1] <= ad[k];
        zr[k+1] <= zr[k];
        ex[k+1] <= ex[k];
        qt[k+1] <= {qt[k][QB-2:0], ge[k]};
        if (k < QB - 1) begin
          rem[k+1] <= {rnext[k], 1'b0};
          dvs[k+1] <= dvs[k];
        end
      end
    end
  end

  // pack stage
  logic [QB-1:0] qf;
  assign qf = qt[QB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_vld <= 1'b0;
    else        o_vld <= vl[QB];
  end

  always_ff @(posedge clk) begin
    if (vl[QB]) begin
      o_addr <= ad[QB];
      if (zr[QB])          o_f32 <= 32'h0;
      else if (qf[QB-1])   o_f32 <= {1'b0, ex[QB], qf[QB-2:1]};
      else                 o_f32 <= {1'b0, ex[QB] - 8'd1, qf[QB-3:0]};
    end
  end
endmodule

// File: rtl/spec_kurt_engine.sv
module spec_kurt_engine #(
  parameter int N_PTS  = 2048,
  parameter int IN_W   = 16,
  parameter int FRAMES = 1000,
  localparam int HALF  = N_PTS / 2,
  localparam int AW    = $clog2(HALF),
  localparam int CNT_W = $clog2(FRAMES + 1),
  localparam int P2_W  = 2 * IN_W + 1,
  localparam int P4_W  = 2 * P2_W,
  localparam int S2_W  = P2_W + CNT_W,
  localparam int S4_W  = P4_W + CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bin_vld,
  input  logic                   bin_sof,
  input  logic signed [IN_W-1:0] bin_re,
  input  logic signed [IN_W-1:0] bin_im,
  input  logic [AW-1:0]          rd_addr,
  output logic [31:0]            rd_data,
  output logic                   done
);
  import sk_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  sk_state_e     st_q, st_d;
  logic [AW-1:0] iss_q, iss_d;
  logic          ison_q, ison_d;
  logic          done_q, done_d;

  logic            f_vld, f_first, f_last;
  logic [AW-1:0]   f_idx;
  logic [P2_W-1:0] f_p2;
  logic [P4_W-1:0] f_p4;
  logic            r_vld;
  logic [AW-1:0]   r_addr;
  logic [31:0]     r_f32;

  ske_front #(.IN_W(IN_W), .HALF(HALF), .FRAMES(FRAMES), .AW(AW), .CNT_W(CNT_W),
              .P2_W(P2_W), .P4_W(P4_W)) u_front (
    .clk(clk), .rst_n(rst_i_n), .acc_en(st_q == SK_ACC), .set_clr(done_d),
    .bin_vld(bin_vld), .bin_sof(bin_sof), .bin_re(bin_re), .bin_im(bin_im),
    .o_vld(f_vld), .o_idx(f_idx), .o_first(f_first), .o_last(f_last),
    .o_p2(f_p2), .o_p4(f_p4));

  // per-bin sums, first frame of a set overwrites
  logic [S2_W-1:0] acc2 [0:HALF-1];
  logic [S4_W-1:0] acc4 [0:HALF-1];

  always_ff @(posedge clk) begin
    if (f_vld) begin
      acc2[f_idx] <= f_first ? S2_W'(f_p2) : acc2[f_idx] + S2_W'(f_p2);
      acc4[f_idx] <= f_first ? S4_W'(f_p4) : acc4[f_idx] + S4_W'(f_p4);
    end
  end

  ske_ratio #(.AW(AW), .FRAMES(FRAMES), .CNT_W(CNT_W), .S2_W(S2_W), .S4_W(S4_W)) u_ratio (
    .clk(clk), .rst_n(rst_i_n), .i_vld(ison_q), .i_addr(iss_q),
    .i_s2(acc2[iss_q]), .i_s4(acc4[iss_q]),
    .o_vld(r_vld), .o_addr(r_addr), .o_f32(r_f32));

  always_comb begin
    st_d   = st_q;
    iss_d  = iss_q;
    ison_d = ison_q;
    done_d = r_vld && (r_addr == AW'(HALF - 1));
    if (st_q == SK_ACC) begin
      if (f_vld && f_last) begin
        st_d   = SK_FIN;
        iss_d  = '0;
        ison_d = 1'b1;
      end
    end else begin
      if (ison_q) begin
        iss_d = iss_q + AW'(1);
        if (iss_q == AW'(HALF - 1)) ison_d = 1'b0;
      end
      if (done_d) st_d = SK_ACC;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= SK_ACC;
      iss_q  <= '0;
      ison_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      iss_q  <= iss_d;
      ison_q <= ison_d;
      done_q <= done_d;
    end
  end

  // result memory
  logic [31:0] res_mem [0:HALF-1];
  logic [31:0] rd_q;
  always_ff @(posedge clk) begin
    if (r_vld) res_mem[r_addr] <= r_f32;
    rd_q <= res_mem[rd_addr];
  end

  assign rd_data = rd_q;
  assign done    = done_q;

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |=> !done_q);
  // R7: results leave the pass in bin order
  a_r7_write_seq: assert property (@(posedge clk) disable iff (!rst_i_n)
    (r_vld && $past(r_vld)) |-> (r_addr == $past(r_addr) + AW'(1)));
  // R7: done follows the write of the top bin
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(done_q) |-> ($past(r_vld) && $past(r_addr) == AW'(HALF - 1)));
  // R9: nothing reaches the sums during a finishing pass
  a_r9_quiet_in_finish: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == SK_FIN) |-> !f_vld);
  // R5: results are positive
  a_r5_sign_clear: assert property (@(posedge clk) disable iff (!rst_i_n)
    r_vld |-> !r_f32[31]);
endmodule

// File: tb/sim_spec_kurt_engine.sv
`timescale 1ns/1ps
module sim_spec_kurt_engine;
  localparam int N_PTS  = 16;
  localparam int HALF   = N_PTS / 2;
  localparam int FRAMES = 4;
  localparam int IN_W   = 16;
  localparam int AW     = $clog2(HALF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bin_vld = 1'b0, bin_sof = 1'b0;
  logic signed [IN_W-1:0] bin_re = '0, bin_im = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic done;

  always #2.5 clk = ~clk;

  spec_kurt_engine #(.N_PTS(N_PTS), .IN_W(IN_W), .FRAMES(FRAMES)) u0 (
    .clk(clk), .rst_n(rst_n), .bin_vld(bin_vld), .bin_sof(bin_sof),
    .bin_re(bin_re), .bin_im(bin_im), .rd_addr(rd_addr), .rd_data(rd_data), .done(done));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0, last_cyc = 0;
  logic [31:0] expq [$];
  logic [255:0] s2 [0:HALF-1];
  logic [255:0] s4 [0:HALF-1];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done) begin done_cnt++; done_cyc = cyc; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void val(input int s, input int f, input int b, output int re, output int im);
    case (b)
      0: begin re = (s == 0) ? 3000 : 1000; im = (s == 0) ? -4000 : 0; end
      1: begin re = 0; im = 0; end
      2: begin re = 100 * (f + 1) + s * 17; im = 0; end
      3: begin re = -32768; im = -32768; end
      4: begin if (f % 2 == 0) begin re = -32768; im = 32767; end else begin re = s; im = 5; end end
      5: begin re = (f == ((s == 0) ? 2 : 0)) ? 7 : 0; im = re; end
      6: begin re = 0; im = f * f * 50 + 1 + s; end
      default: begin re = f * 13 - 20 + s; im = 300; end
    endcase
  endfunction

  function automatic string tag(input int b);
    case (b)
      0: return "R4";
      1: return "R6";
      2: return "R5 R3";
      3: return "R10";
      4: return "R10 R5";
      5: return "R5";
      6: return "R2";
      default: return "R2 R7";
    endcase
  endfunction

  // exact expected word: exponent by search, truncated fraction
  function automatic logic [31:0] expect_f32(input logic [255:0] a2, input logic [255:0] a4);
    logic [255:0] num, den, m;
    int e;
    if (a2 == 0) return 32'h0;
    num = a4 * FRAMES;
    den = a2 * a2;
    e = -60;
    for (int t = 60; t >= -60; t--) begin
      if ((t >= 0) ? (num >= (den << t)) : ((num << (-t)) >= den)) begin e = t; break; end
    end
    if (23 - e >= 0) m = (num << (23 - e)) / den;
    else             m = num / (den << (e - 23));
    return {1'b0, 8'(e + 127), m[22:0]};
  endfunction

  task automatic drive(input logic v, input logic sof, input int re, input int im);
    @(negedge clk);
    bin_vld = v; bin_sof = sof;
    bin_re = IN_W'(re); bin_im = IN_W'(im);
  endtask

  task automatic send_set(input int s);
    int re, im;
    logic [255:0] p;
    for (int b = 0; b < HALF; b++) begin s2[b] = 0; s4[b] = 0; end
    for (int f = 0; f < FRAMES; f++) begin
      for (int b = 0; b < N_PTS; b++) begin
        if (b == 3) drive(1'b0, 1'b0, 32767, 32767);          // R3 gap with junk data
        if (b < HALF) begin
          val(s, f, b, re, im);
          p = 256'(re * re) + 256'(im * im);
          s2[b] = s2[b] + p;
          s4[b] = s4[b] + p * p;
        end else begin
          re = 32767; im = 32767;                           // R2 upper half
        end
        drive(1'b1, b == 0, re, im);
        if (f == FRAMES - 1 && b == HALF - 1) last_cyc = cyc;
      end
      drive(1'b1, 1'b0, -32768, 32767);                       // R2 stray bins
      drive(1'b1, 1'b0, 32767, -32768);
      drive(1'b0, 1'b0, 0, 0);
    end
    for (int b = 0; b < HALF; b++) expq.push_back(expect_f32(s2[b], s4[b]));
  endtask

  task automatic drain_set(input int s);
    logic [31:0] e;
    while (done_cnt < s + 1) @(negedge clk);
    n_chk++;
    if (done_cyc - last_cyc > HALF + 60) begin
      n_fail++;
      $display("FAIL R8 actual=%0d expected<=%0d", done_cyc - last_cyc, HALF + 60);
    end
    @(negedge clk);
    check("R7 done width", {31'b0, done}, 32'h0);
    for (int b = 0; b < HALF; b++) begin
      rd_addr = AW'(b);
      @(negedge clk);
      e = expq.pop_front();
      check((s == 1) ? {"R9 ", tag(b)} : tag(b), rd_data, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {31'b0, done}, 32'h0);
    send_set(0);
    for (int b = 0; b < N_PTS; b++) drive(1'b1, b == 0, 32767, -32768);  // R9 during finish
    drive(1'b0, 1'b0, 0, 0);
    drain_set(0);
    send_set(1);
    drain_set(1);
    repeat (3) @(negedge clk);
    check("R7 done count", 32'(done_cnt), 32'd2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule